// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

This block is a synthesizable model of a serial configuration memory. It holds a bit array fixed by a parameter and shifts out one bit on every rising clock edge while it is selected. Several identical units can be chained to form one long bit stream. Each unit's active-low cascade output drives the active-low chip select of the next unit. When a unit has presented its final bit, it releases its data line and pulls the cascade output low, so that the next unit in the chain takes over.

A single control pin serves as both reset and output enable. A polarity input decides which level of that pin means which function. In one setting, a high level resets the unit and a low level enables output. In the other setting, a low level resets the unit and a high level enables output. When reset is active, the unit returns to its first bit. The electrical high-impedance state of the data line is modelled by a separate valid flag. The data bit is held at zero whenever that flag is low.

Top module: `serial_cfg_rom`

## Requirements
- R1: After the synchronous `rst` input, `cas_en_n` is 1 and `dat_vld` is 0, and `dat_vld` stays 0 until a clock edge has shifted out a bit.
- R2: Each rising edge taken while the unit is selected and enabled presents the next bit. After the k-th such edge since reset (k counted from 1), `dat_out` equals `ROM_BITS[k-1]`, so bit 0 of the parameter is sent first.
- R3: With `pin_pol` = 0, `ctl_pin` = 1 resets the unit and `ctl_pin` = 0 enables output.
- R4: With `pin_pol` = 1, `ctl_pin` = 0 resets the unit and `ctl_pin` = 1 enables output.
- R5: A clock edge that samples the pin in its reset level returns the pointer to bit 0 and sets `cas_en_n` back to 1. This holds even after the hand-off has happened.
- R6: While `sel_n` = 1, `dat_vld` is 0 and the pointer does not move. The first edge after `sel_n` returns to 0 presents the bit that follows the last one shown.
- R7: The first enabled edge after bit `DEPTH-1` has been shown drives `cas_en_n` to 0 and `dat_vld` to 0. Both stay there until a reset.
- R8: A second unit whose `sel_n` is tied to the first unit's `cas_en_n` presents its own bit 0 on the edge after the hand-off, and then its following bits on later edges.
- R9: `dat_vld` is 0 at once, without waiting for a clock edge, whenever `sel_n` is 1 or the pin is at its reset level. `dat_out` is 0 whenever `dat_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; a bit is presented on each rising edge |
| rst | input | 1 | Synchronous active-high reset of the unit |
| pin_pol | input | 1 | Polarity of the pin: 0 = high resets / low enables; 1 = low resets / high enables |
| ctl_pin | input | 1 | Combined reset and output-enable pin |
| sel_n | input | 1 | Active-low chip select |
| dat_out | output | 1 | Serial data bit; 0 when not valid |
| dat_vld | output | 1 | 1 while the data line is driven; 0 models high impedance |
| cas_en_n | output | 1 | Active-low cascade enable for the next unit |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `pin_pol` changes only while the unit is being reset, so that the decoded reset and enable levels never flip in the middle of a stream. The bench follows both rules. It opens every scenario with a `rst` pulse and sets `pin_pol` before that pulse. It changes `ctl_pin` and `sel_n` only on falling edges. The cascade check chains two units that share the pin and the polarity, which keeps their resets aligned.

// File: rtl/scrom_pkg.sv
package scrom_pkg;

    // Meaning of the combined control pin
    typedef enum logic {
        POL_HI_RESETS = 1'b0,   // high = reset, low = output enable
        POL_LO_RESETS = 1'b1    // low = reset, high = output enable
    } pin_pol_e;

    // Decoded pin functions
    typedef struct packed {
        logic rst_act;
        logic oe_act;
    } pin_ctl_t;

    // Sequencer phase
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,     // nothing presented since reset
        PH_STREAM   = 2'd1,     // a bit is held on the output register
        PH_RELEASED = 2'd2      // all bits sent, hand-off taken
    } seq_ph_e;

    function automatic pin_ctl_t decode_pin(input pin_pol_e pol, input logic lvl);
        pin_ctl_t r;
        r.rst_act = (pol == POL_HI_RESETS) ? lvl : ~lvl;
        r.oe_act  = ~r.rst_act;
        return r;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    function automatic int unsigned idx_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/scrom_pin_ctl.sv
module scrom_pin_ctl
    import scrom_pkg::*;
(
    input  logic     pin_pol,
    input  logic     ctl_pin,
    output pin_ctl_t ctl
);
    always_comb begin
        ctl = decode_pin(pin_pol_e'(pin_pol), ctl_pin);
    end
endmodule

// File: rtl/scrom_seq.sv
module scrom_seq
    import scrom_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter logic [DEPTH-1:0] ROM_BITS = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pin_rst,
    input  logic                       advance,
    output seq_ph_e                    phase,
    output logic [cnt_bits(DEPTH)-1:0] bit_cnt,
    output logic                       cur_bit
);
    localparam int unsigned CW = cnt_bits(DEPTH);
    localparam int unsigned AW = idx_bits(DEPTH);
    localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH);

    logic [AW-1:0] rd_idx;

    assign rd_idx = bit_cnt[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst || pin_rst) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            cur_bit <= 1'b0;
        end else if (advance) begin
            unique case (phase)
                PH_IDLE, PH_STREAM: begin
                    if (bit_cnt == LAST_CNT) begin
                        phase <= PH_RELEASED;
                    end else begin
                        cur_bit <= ROM_BITS[rd_idx];
                        bit_cnt <= bit_cnt + 1'b1;
                        phase   <= PH_STREAM;
                    end
                end
                default: begin
                    phase <= PH_RELEASED;
                end
            endcase
        end
    end
endmodule

// File: rtl/scrom_out_drv.sv
module scrom_out_drv
    import scrom_pkg::*;
(
    input  seq_ph_e phase,
    input  logic    cur_bit,
    input  logic    sel_n,
    input  logic    oe_act,
    output logic    dat_out,
    output logic    dat_vld,
    output logic    cas_en_n
);
    always_comb begin
        dat_vld  = (phase == PH_STREAM) && !sel_n && oe_act;
        dat_out  = dat_vld && cur_bit;
        cas_en_n = (phase != PH_RELEASED);
    end
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom
    import scrom_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter logic [DEPTH-1:0] ROM_BITS = 64'hA5C3_0F96_3C5A_E71D
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_pol,
    input  logic ctl_pin,
    input  logic sel_n,
    output logic dat_out,
    output logic dat_vld,
    output logic cas_en_n
);
    localparam int unsigned CW = cnt_bits(DEPTH);

    pin_ctl_t          pin_ctl;
    seq_ph_e           phase;
    logic [CW-1:0]     bit_cnt;
    logic              cur_bit;
    logic              advance;

    scrom_pin_ctl u_pin (
        .pin_pol (pin_pol),
        .ctl_pin (ctl_pin),
        .ctl     (pin_ctl)
    );

    assign advance = !sel_n && pin_ctl.oe_act;

    scrom_seq #(
        .DEPTH    (DEPTH),
        .ROM_BITS (ROM_BITS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .pin_rst (pin_ctl.rst_act),
        .advance (advance),
        .phase   (phase),
        .bit_cnt (bit_cnt),
        .cur_bit (cur_bit)
    );

    scrom_out_drv u_drv (
        .phase    (phase),
        .cur_bit  (cur_bit),
        .sel_n    (sel_n),
        .oe_act   (pin_ctl.oe_act),
        .dat_out  (dat_out),
        .dat_vld  (dat_vld),
        .cas_en_n (cas_en_n)
    );
endmodule

// File: rtl/scrom_checker.sv
module scrom_checker
    import scrom_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       sel_n,
    input logic                       pin_rst,
    input logic                       dat_out,
    input logic                       dat_vld,
    input logic                       cas_en_n,
    input logic [cnt_bits(DEPTH)-1:0] bit_cnt
);
    localparam int unsigned CW = cnt_bits(DEPTH);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CW'(DEPTH));

    p_pin_reset_r5: assert property (@(posedge clk) disable iff (rst)
        pin_rst |=> (cas_en_n && !dat_vld && bit_cnt == '0));

    p_hold_when_deselected_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !pin_rst) |=> $stable(bit_cnt));

    p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> !dat_vld);

    p_release_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (!cas_en_n && !pin_rst) |=> !cas_en_n);

    p_release_after_full_r7: assert property (@(posedge clk) disable iff (rst)
        !cas_en_n |-> (bit_cnt == CW'(DEPTH) && !dat_vld));

    p_zero_when_invalid_r9: assert property (@(posedge clk) disable iff (rst)
        !dat_vld |-> !dat_out);
endmodule

bind serial_cfg_rom scrom_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_n),
    .pin_rst  (pin_ctl.rst_act),
    .dat_out  (dat_out),
    .dat_vld  (dat_vld),
    .cas_en_n (cas_en_n),
    .bit_cnt  (bit_cnt)
);

// File: tb/serial_cfg_rom_test.sv
`timescale 1ns/1ps
module serial_cfg_rom_test;
    localparam int unsigned DEPTH = 16;
    localparam logic [DEPTH-1:0] BITS_A = 16'hB2D5;
    localparam logic [DEPTH-1:0] BITS_B = 16'h6C39;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_pol = 1'b0;
    logic ctl_pin = 1'b0;
    logic sel_n = 1'b1;
    logic dat_a, vld_a, cas_a;
    logic dat_b, vld_b, cas_b;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    serial_cfg_rom #(.DEPTH(DEPTH), .ROM_BITS(BITS_A)) uut (
        .clk(clk), .rst(rst), .pin_pol(pin_pol), .ctl_pin(ctl_pin),
        .sel_n(sel_n), .dat_out(dat_a), .dat_vld(vld_a), .cas_en_n(cas_a)
    );

    serial_cfg_rom #(.DEPTH(DEPTH), .ROM_BITS(BITS_B)) uut2 (
        .clk(clk), .rst(rst), .pin_pol(pin_pol), .ctl_pin(ctl_pin),
        .sel_n(cas_a), .dat_out(dat_b), .dat_vld(vld_b), .cas_en_n(cas_b)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // reset pulse; pin_pol/ctl_pin/sel_n set by the caller beforehand
    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        pin_pol = 1'b0; ctl_pin = 1'b0; sel_n = 1'b1;
        do_reset();
        chk(cas_a == 1'b1, "R1 cas_en_n", int'(cas_a), 1);
        chk(vld_a == 1'b0, "R1 dat_vld", int'(vld_a), 0);
        sel_n = 1'b0;
        #1;
        chk(vld_a == 1'b0, "R1 no bit before edge", int'(vld_a), 0);
    endtask

    task automatic t_stream_cascade();
        pin_pol = 1'b0; ctl_pin = 1'b0; sel_n = 1'b0;
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            tick();
            chk(vld_a && dat_a == BITS_A[k], "R2 R3 stream bit",
                int'({vld_a, dat_a}), int'({1'b1, BITS_A[k]}));
        end
        chk(cas_b == 1'b1, "R8 second unit waits", int'(cas_b), 1);
        tick();
        chk(!cas_a && !vld_a, "R7 hand-off", int'({cas_a, vld_a}), 0);
        chk(!vld_b, "R8 gap cycle", int'(vld_b), 0);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(vld_b && dat_b == BITS_B[k], "R8 cascade bit",
                int'({vld_b, dat_b}), int'({1'b1, BITS_B[k]}));
            chk(!cas_a && !vld_a, "R7 stays released", int'({cas_a, vld_a}), 0);
        end
    endtask

    task automatic t_pin_reset();
        pin_pol = 1'b0; ctl_pin = 1'b0; sel_n = 1'b0;
        do_reset();
        tick(); tick(); tick();
        ctl_pin = 1'b1;
        #1;
        chk(!vld_a && !dat_a, "R9 reset level drops valid", int'({vld_a, dat_a}), 0);
        tick();
        ctl_pin = 1'b0;
        #1;
        chk(!vld_a, "R5 pointer cleared", int'(vld_a), 0);
        tick();
        chk(vld_a && dat_a == BITS_A[0], "R5 restart at bit 0",
            int'({vld_a, dat_a}), int'({1'b1, BITS_A[0]}));
        for (int k = 1; k < DEPTH; k++) tick();
        tick();
        chk(!cas_a, "R7 released before pin reset", int'(cas_a), 0);
        ctl_pin = 1'b1;
        tick();
        chk(cas_a, "R5 cascade restored", int'(cas_a), 1);
        ctl_pin = 1'b0;
        tick();
        chk(vld_a && dat_a == BITS_A[0], "R5 stream after release",
            int'({vld_a, dat_a}), int'({1'b1, BITS_A[0]}));
    endtask

    task automatic t_mode1();
        pin_pol = 1'b1; ctl_pin = 1'b0; sel_n = 1'b0;
        do_reset();
        tick();
        chk(!vld_a, "R4 low pin holds reset", int'(vld_a), 0);
        ctl_pin = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(vld_a && dat_a == BITS_A[k], "R4 high pin enables",
                int'({vld_a, dat_a}), int'({1'b1, BITS_A[k]}));
        end
        ctl_pin = 1'b0;
        #1;
        chk(!vld_a, "R4 R9 low pin disables", int'(vld_a), 0);
        tick();
        ctl_pin = 1'b1;
        tick();
        chk(vld_a && dat_a == BITS_A[0], "R4 reset to bit 0",
            int'({vld_a, dat_a}), int'({1'b1, BITS_A[0]}));
    endtask

    task automatic t_deselect_hold();
        pin_pol = 1'b0; ctl_pin = 1'b0; sel_n = 1'b0;
        do_reset();
        tick(); tick(); tick();
        sel_n = 1'b1;
        #1;
        chk(!vld_a && !dat_a, "R6 R9 deselect quiet", int'({vld_a, dat_a}), 0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(!vld_a && cas_a, "R6 held while deselected", int'({vld_a, cas_a}), 1);
        end
        sel_n = 1'b0;
        tick();
        chk(vld_a && dat_a == BITS_A[3], "R6 resumes at next bit",
            int'({vld_a, dat_a}), int'({1'b1, BITS_A[3]}));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stream_cascade();
        t_pin_reset();
        t_mode1();
        t_deselect_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule